// File: doc/BRIEF.md
# Load/Store Function-Unit Sequencer

This block is the controller of one function unit in a scoreboard-scheduled out-of-order core. Each issued operation is one of three kinds: an integer add, a load or a store. The unit keeps the operation's opcode and immediate, captures the two source operands in separate registers, and forms a sum of the first operand and either the immediate or the second operand. That sum is the add result, or the memory address for a load or a store.

The unit works through a chain of request/go handshakes with an external scheduler. It raises a request output and waits for the matching go input. An add goes through issue, read and write. A load goes through issue, read, address and write. A store goes through issue, read, address and store. A go input has effect only in a cycle where its own request is raised. No state bit is therefore ever set and cleared in the same cycle. The memory side is only a set of ports: a registered address, the store data (the second operand) and a load-data input that is sampled when the write is accepted.

Top module: `lsu_fu_ctrl`

## Requirements
- R1: After a synchronous reset, `busy_o` and all four request outputs are low.
- R2: `issue_i` is accepted only while `busy_o` is low. The next cycle shows `busy_o` and `rd_req_o` high. An issue while busy has no effect on the requests, the opcode or any output.
- R3: Add: `go_rd_i` with `rd_req_o` raises `wr_req_o` and never `adr_req_o`. `go_wr_i` with `wr_req_o` then drives the sum to `result_o` and drops `busy_o`, both in the next cycle.
- R4: Load: an accepted read raises `adr_req_o`. An accepted `go_adr_i` registers the sum on `addr_o` and raises `wr_req_o`. An accepted write loads `result_o` with `ld_data_i` from that cycle and drops `busy_o`.
- R5: Store: an accepted read raises `adr_req_o`. An accepted address registers `addr_o` and raises `st_req_o`. `st_data_o` is the captured second operand. An accepted `go_st_i` drops `busy_o`, never raises `wr_req_o` and leaves `result_o` unchanged.
- R6: A go input that arrives while its own request is low changes no request, no busy flag and no data output.
- R7: The opcode and immediate are frozen when issue is accepted. The sources are frozen when the read is accepted. Later changes on those inputs do not affect the result, the address or the store data.
- R8: The sum is `src1 + imm` when `use_imm_i` was 1 at issue, and `src1 + src2` when it was 0, modulo 2^DATA_W.
- R9: At most one request output is high at a time, and `busy_o` is high exactly when one request output is high.
- R10: `op_kind_i` encoding: 0 = add, 1 = load, 2 = store, 3 = handled as add.
- R11: An issue that arrives in the same cycle as an accepted `go_wr_i` or `go_st_i` is dropped. The unit is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Issue strobe from the scheduler |
| op_kind_i | input | 2 | Operation kind (R10) |
| use_imm_i | input | 1 | Select the immediate as the second addend |
| imm_i | input | DATA_W | Immediate value, captured at issue |
| go_rd_i | input | 1 | Grant to read operands |
| src1_i | input | DATA_W | First source operand |
| src2_i | input | DATA_W | Second source operand |
| go_adr_i | input | 1 | Grant to form the address |
| go_wr_i | input | 1 | Grant to write back |
| ld_data_i | input | DATA_W | Data returned by the load |
| go_st_i | input | 1 | Grant to perform the store |
| busy_o | output | 1 | Unit holds an operation |
| rd_req_o | output | 1 | Operand read requested |
| adr_req_o | output | 1 | Address step requested |
| wr_req_o | output | 1 | Write-back requested |
| st_req_o | output | 1 | Store requested |
| addr_o | output | DATA_W | Registered memory address |
| st_data_o | output | DATA_W | Store data (second operand) |
| result_o | output | DATA_W | Write-back value |

## Verification
Two functions can land on the same edge. One is the retirement of an operation by an accepted write or store. The other is a new issue. The bench raises `issue_i` in the same cycle as an accepted `go_wr_i` and also as an accepted `go_st_i`. In the next cycle it expects `busy_o` and `rd_req_o` low, with the old result kept. It also sends go pulses whose request is not raised, while the unit waits on a different request. These must leave the pending request and the data outputs as they were.

// File: rtl/lsu_fu_pkg.sv
package lsu_fu_pkg;

    typedef enum logic [1:0] {
        OPK_ADD     = 2'd0,
        OPK_LOAD    = 2'd1,
        OPK_STORE   = 2'd2,
        OPK_ADD_ALT = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_READ  = 3'd1,
        SQ_ADDR  = 3'd2,
        SQ_WRITE = 3'd3,
        SQ_STORE = 3'd4
    } seq_state_e;

    typedef struct packed {
        op_kind_e kind;
        logic     use_imm;
    } op_word_t;

    function automatic logic is_mem_op(op_kind_e k);
        return (k == OPK_LOAD) || (k == OPK_STORE);
    endfunction

endpackage

// File: rtl/lsu_fu_chain.sv
module lsu_fu_chain
    import lsu_fu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     issue_i,
    input  op_kind_e kind_i,
    input  logic     go_rd_i,
    input  logic     go_adr_i,
    input  logic     go_wr_i,
    input  logic     go_st_i,
    output logic     acc_issue_o,
    output logic     acc_rd_o,
    output logic     acc_adr_o,
    output logic     acc_wr_o,
    output logic     acc_st_o,
    output logic     busy_o,
    output logic     rd_req_o,
    output logic     adr_req_o,
    output logic     wr_req_o,
    output logic     st_req_o
);

    typedef struct packed {
        seq_state_e st;
    } chain_t;

    chain_t c_d, c_q;

    always_comb begin
        c_d         = c_q;
        acc_issue_o = issue_i  && (c_q.st == SQ_IDLE);
        acc_rd_o    = go_rd_i  && (c_q.st == SQ_READ);
        acc_adr_o   = go_adr_i && (c_q.st == SQ_ADDR);
        acc_wr_o    = go_wr_i  && (c_q.st == SQ_WRITE);
        acc_st_o    = go_st_i  && (c_q.st == SQ_STORE);

        unique case (c_q.st)
            SQ_IDLE:  if (acc_issue_o) c_d.st = SQ_READ;
            SQ_READ:  if (acc_rd_o)    c_d.st = is_mem_op(kind_i) ? SQ_ADDR : SQ_WRITE;
            SQ_ADDR:  if (acc_adr_o)   c_d.st = (kind_i == OPK_STORE) ? SQ_STORE : SQ_WRITE;
            SQ_WRITE: if (acc_wr_o)    c_d.st = SQ_IDLE;
            SQ_STORE: if (acc_st_o)    c_d.st = SQ_IDLE;
            default:                   c_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '{st: SQ_IDLE};
        else     c_q <= c_d;
    end

    assign busy_o    = (c_q.st != SQ_IDLE);
    assign rd_req_o  = (c_q.st == SQ_READ);
    assign adr_req_o = (c_q.st == SQ_ADDR);
    assign wr_req_o  = (c_q.st == SQ_WRITE);
    assign st_req_o  = (c_q.st == SQ_STORE);

endmodule

// File: rtl/lsu_fu_opnds.sv
module lsu_fu_opnds
    import lsu_fu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_issue_i,
    input  logic              acc_rd_i,
    input  logic              acc_wr_i,
    input  logic [1:0]        op_kind_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic [DATA_W-1:0] src1_i,
    input  logic [DATA_W-1:0] src2_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic [DATA_W-1:0] sum_i,
    output op_word_t          op_o,
    output logic [DATA_W-1:0] opa_o,
    output logic [DATA_W-1:0] opb_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic [DATA_W-1:0] result_o
);

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        op_word_t op;
        word_t    imm;
        word_t    a;
        word_t    b;
        word_t    res;
    } opnd_t;

    opnd_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (acc_issue_i) begin
            r_d.op.kind    = op_kind_e'(op_kind_i);
            r_d.op.use_imm = use_imm_i;
            r_d.imm        = imm_i;
        end
        if (acc_rd_i) begin
            r_d.a = src1_i;
            r_d.b = src2_i;
        end
        if (acc_wr_i) begin
            r_d.res = (r_q.op.kind == OPK_LOAD) ? ld_data_i : sum_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign op_o      = r_q.op;
    assign opa_o     = r_q.a;
    assign opb_o     = r_q.op.use_imm ? r_q.imm : r_q.b;
    assign st_data_o = r_q.b;
    assign result_o  = r_q.res;

endmodule

// File: rtl/lsu_fu_agen.sv
module lsu_fu_agen #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_adr_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W-1:0] addr_o
);

    logic [DATA_W-1:0] addr_d, addr_q;

    always_comb begin
        sum_o  = opa_i + opb_i;
        addr_d = acc_adr_i ? sum_o : addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/lsu_fu_ctrl.sv
module lsu_fu_ctrl
    import lsu_fu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic [1:0]        op_kind_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic              go_rd_i,
    input  logic [DATA_W-1:0] src1_i,
    input  logic [DATA_W-1:0] src2_i,
    input  logic              go_adr_i,
    input  logic              go_wr_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              go_st_i,
    output logic              busy_o,
    output logic              rd_req_o,
    output logic              adr_req_o,
    output logic              wr_req_o,
    output logic              st_req_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic [DATA_W-1:0] result_o
);

    logic              acc_issue, acc_rd, acc_adr, acc_wr, acc_st;
    op_word_t          op_q;
    logic [DATA_W-1:0] opa, opb, sum;

    lsu_fu_chain u_chain (
        .clk        (clk),
        .rst        (rst),
        .issue_i    (issue_i),
        .kind_i     (op_q.kind),
        .go_rd_i    (go_rd_i),
        .go_adr_i   (go_adr_i),
        .go_wr_i    (go_wr_i),
        .go_st_i    (go_st_i),
        .acc_issue_o(acc_issue),
        .acc_rd_o   (acc_rd),
        .acc_adr_o  (acc_adr),
        .acc_wr_o   (acc_wr),
        .acc_st_o   (acc_st),
        .busy_o     (busy_o),
        .rd_req_o   (rd_req_o),
        .adr_req_o  (adr_req_o),
        .wr_req_o   (wr_req_o),
        .st_req_o   (st_req_o)
    );

    lsu_fu_opnds #(.DATA_W(DATA_W)) u_opnds (
        .clk        (clk),
        .rst        (rst),
        .acc_issue_i(acc_issue),
        .acc_rd_i   (acc_rd),
        .acc_wr_i   (acc_wr),
        .op_kind_i  (op_kind_i),
        .use_imm_i  (use_imm_i),
        .imm_i      (imm_i),
        .src1_i     (src1_i),
        .src2_i     (src2_i),
        .ld_data_i  (ld_data_i),
        .sum_i      (sum),
        .op_o       (op_q),
        .opa_o      (opa),
        .opb_o      (opb),
        .st_data_o  (st_data_o),
        .result_o   (result_o)
    );

    lsu_fu_agen #(.DATA_W(DATA_W)) u_agen (
        .clk      (clk),
        .rst      (rst),
        .acc_adr_i(acc_adr),
        .opa_i    (opa),
        .opb_i    (opb),
        .sum_o    (sum),
        .addr_o   (addr_o)
    );

    logic unused_st;
    assign unused_st = acc_st;

endmodule

// File: rtl/lsu_fu_ctrl_chk.sv
module lsu_fu_ctrl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_i,
    input logic              go_rd_i,
    input logic              go_adr_i,
    input logic              go_wr_i,
    input logic              go_st_i,
    input logic              busy_o,
    input logic              rd_req_o,
    input logic              adr_req_o,
    input logic              wr_req_o,
    input logic              st_req_o,
    input logic [DATA_W-1:0] addr_o,
    input logic [DATA_W-1:0] st_data_o,
    input logic [DATA_W-1:0] result_o
);

    p_one_req_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_req_o, adr_req_o, wr_req_o, st_req_o}));

    p_busy_req_r9: assert property (@(posedge clk) disable iff (rst)
        busy_o == (rd_req_o | adr_req_o | wr_req_o | st_req_o));

    p_issue_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !busy_o) |=> (busy_o && rd_req_o));

    p_rd_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !go_rd_i) |=> rd_req_o);

    p_adr_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (adr_req_o && !go_adr_i) |=> (adr_req_o && $stable(addr_o)));

    p_wr_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && !go_wr_i) |=> (wr_req_o && $stable(result_o)));

    p_st_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (st_req_o && !go_st_i) |=> (st_req_o && $stable(st_data_o)));

    p_wr_done_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && go_wr_i) |=> !busy_o);

    p_st_done_r5: assert property (@(posedge clk) disable iff (rst)
        (st_req_o && go_st_i) |=> (!busy_o && $stable(result_o)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !issue_i) |=> !busy_o);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> !busy_o);

endmodule

bind lsu_fu_ctrl lsu_fu_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lsu_fu_ctrl_bench.sv
`timescale 1ns/1ps
module lsu_fu_ctrl_bench;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         issue_i, use_imm_i, go_rd_i, go_adr_i, go_wr_i, go_st_i;
    logic [1:0]   op_kind_i;
    logic [W-1:0] imm_i, src1_i, src2_i, ld_data_i;
    logic         busy_o, rd_req_o, adr_req_o, wr_req_o, st_req_o;
    logic [W-1:0] addr_o, st_data_o, result_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    lsu_fu_ctrl #(.DATA_W(W)) u_lsu_fu_ctrl (.*);

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [1:0]   kind;
        logic         use_imm;
        logic [W-1:0] imm;
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] ld;
        logic [W-1:0] exp_addr;
        logic [W-1:0] exp_res;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 32'h0,        32'h5,        32'h7,        32'h0,        32'h0,        32'hC},
        '{2'd0, 1'b1, 32'h10,       32'h100,      32'h999,      32'h0,        32'h0,        32'h110},
        '{2'd1, 1'b1, 32'h4,        32'h1000,     32'h77,       32'hDEADBEEF, 32'h1004,     32'hDEADBEEF},
        '{2'd1, 1'b0, 32'h0,        32'h2000,     32'h20,       32'h12345678, 32'h2020,     32'h12345678},
        '{2'd2, 1'b1, 32'h8,        32'h3000,     32'hCAFEF00D, 32'h0,        32'h3008,     32'h0},
        '{2'd2, 1'b0, 32'h0,        32'hFFFFFFFF, 32'h2,        32'h0,        32'h1,        32'h0},
        '{2'd3, 1'b0, 32'h0,        32'hFFFFFFF0, 32'h20,       32'h0,        32'h0,        32'h10},
        '{2'd0, 1'b1, 32'hFFFFFFFF, 32'h1,        32'h5,        32'h0,        32'h0,        32'h0}
    };

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        issue_i = 0; go_rd_i = 0; go_adr_i = 0; go_wr_i = 0; go_st_i = 0;
    endtask

    function automatic logic [4:0] reqs();
        return {busy_o, rd_req_o, adr_req_o, wr_req_o, st_req_o};
    endfunction

    task automatic run_vec(input vec_t v);
        logic [W-1:0] old_res;
        old_res = result_o;
        @(negedge clk);
        issue_i = 1; op_kind_i = v.kind; use_imm_i = v.use_imm; imm_i = v.imm;
        @(negedge clk);
        issue_i = 0;
        chk({27'd0, reqs()}, 32'b11000, "R2 issue raises busy and read request");
        op_kind_i = ~v.kind; use_imm_i = ~v.use_imm; imm_i = 32'h5A5A5A5A;
        src1_i = v.s1; src2_i = v.s2; go_rd_i = 1;
        @(negedge clk);
        go_rd_i = 0; src1_i = 32'hBAD0BAD0; src2_i = 32'h0BAD0BAD;
        if (v.kind == 2'd0 || v.kind == 2'd3) begin
            chk({27'd0, reqs()}, 32'b10010, "R3 R10 add goes to write request");
            ld_data_i = 32'hFFFF0000; go_wr_i = 1;
            @(negedge clk);
            go_wr_i = 0;
            chk(result_o, v.exp_res, "R3 R7 R8 add result");
            chk({31'd0, busy_o}, 32'd0, "R3 busy cleared");
        end else begin
            chk({27'd0, reqs()}, 32'b10100, "R4 R5 memory op goes to address request");
            go_adr_i = 1;
            @(negedge clk);
            go_adr_i = 0;
            chk(addr_o, v.exp_addr, "R4 R5 R7 R8 address");
            if (v.kind == 2'd1) begin
                chk({27'd0, reqs()}, 32'b10010, "R4 load goes to write request");
                ld_data_i = v.ld; go_wr_i = 1;
                @(negedge clk);
                go_wr_i = 0; ld_data_i = 32'h0;
                chk(result_o, v.exp_res, "R4 load data written back");
                chk({31'd0, busy_o}, 32'd0, "R4 busy cleared");
            end else begin
                chk({27'd0, reqs()}, 32'b10001, "R5 store goes to store request");
                chk(st_data_o, v.s2, "R5 store data is second operand");
                go_st_i = 1;
                @(negedge clk);
                go_st_i = 0;
                chk({27'd0, reqs()}, 32'd0, "R5 store retires with no write request");
                chk(result_o, old_res, "R5 result untouched by store");
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] keep;
        idle_inputs();
        op_kind_i = 0; use_imm_i = 0; imm_i = 0; src1_i = 0; src2_i = 0; ld_data_i = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        chk({27'd0, reqs()}, 32'd0, "R1 reset state");

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6: stray go pulses while idle
        keep = result_o;
        @(negedge clk);
        go_rd_i = 1; go_adr_i = 1; go_wr_i = 1; go_st_i = 1; ld_data_i = 32'h11111111;
        @(negedge clk);
        idle_inputs();
        chk({27'd0, reqs()}, 32'd0, "R6 go pulses ignored while idle");
        chk(result_o, keep, "R6 result kept while idle");

        // R6 R2: load waiting on read; wrong go pulses and second issue
        issue_i = 1; op_kind_i = 2'd1; use_imm_i = 1; imm_i = 32'h40;
        @(negedge clk);
        issue_i = 0;
        go_adr_i = 1; go_wr_i = 1; go_st_i = 1;
        @(negedge clk);
        idle_inputs();
        chk({27'd0, reqs()}, 32'b11000, "R6 read request held against other go inputs");
        issue_i = 1; op_kind_i = 2'd2; use_imm_i = 0;
        @(negedge clk);
        issue_i = 0;
        chk({27'd0, reqs()}, 32'b11000, "R2 issue while busy ignored");
        src1_i = 32'h500; src2_i = 32'h9; go_rd_i = 1;
        @(negedge clk);
        go_rd_i = 0;
        chk({27'd0, reqs()}, 32'b10100, "R2 R7 opcode from first issue kept");
        keep = addr_o;
        go_wr_i = 1; go_st_i = 1; go_rd_i = 1;
        @(negedge clk);
        idle_inputs();
        chk({27'd0, reqs()}, 32'b10100, "R6 address request held");
        chk(addr_o, keep, "R6 address unchanged by stray go");
        go_adr_i = 1;
        @(negedge clk);
        go_adr_i = 0;
        chk(addr_o, 32'h540, "R7 R8 immediate kept from first issue");

        // R11: issue together with accepted write
        keep = result_o;
        go_st_i = 1;
        @(negedge clk);
        go_st_i = 0;
        chk({27'd0, reqs()}, 32'b10010, "R6 store go ignored on load write request");
        chk(result_o, keep, "R6 result unchanged by stray store go");
        ld_data_i = 32'h600DF00D; go_wr_i = 1; issue_i = 1; op_kind_i = 2'd0;
        @(negedge clk);
        idle_inputs();
        chk({27'd0, reqs()}, 32'd0, "R11 issue dropped on write retirement");
        chk(result_o, 32'h600DF00D, "R4 load result with overlapping issue");

        // R11: issue together with accepted store
        run_vec('{2'd2, 1'b1, 32'h2, 32'h10, 32'h33, 32'h0, 32'h12, 32'h0});
        @(negedge clk);
        issue_i = 1; op_kind_i = 2'd2; use_imm_i = 0;
        @(negedge clk);
        issue_i = 0; src1_i = 1; src2_i = 2; go_rd_i = 1;
        @(negedge clk);
        go_rd_i = 0; go_adr_i = 1;
        @(negedge clk);
        go_adr_i = 0; go_st_i = 1; issue_i = 1;
        @(negedge clk);
        idle_inputs();
        chk({27'd0, reqs()}, 32'd0, "R11 issue dropped on store retirement");

        // R1: reset in mid-operation
        issue_i = 1; op_kind_i = 2'd1;
        @(negedge clk);
        issue_i = 0; rst = 1;
        @(negedge clk);
        rst = 0;
        chk({27'd0, reqs()}, 32'd0, "R1 reset aborts operation");
        chk(addr_o, 32'd0, "R1 address cleared");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule